// File: doc/BRIEF.md
# Remote Terminal Message Validator

This block sits behind a serial-bus word receiver on a command/response avionics bus. It receives decoded words: the sync type, 16 data bits, a parity-good flag, a Manchester-good flag and the channel the word arrived on. From these it follows one message per frame. For each frame it builds a 16-bit status word that describes the faults and attributes of that message. When the frame closes, it publishes the status word together with a one-cycle done pulse.

The block serves two terminal addresses at once. When a data word belongs to a receive message for either terminal, the block computes that word's position in a shared buffer and issues a write. The buffer gives each subaddress a 32-word slot. The first terminal's slots start at address 0 and the second terminal's slots start at 0x800. The write strobe, address and data drive a plain RAM write port.

A frame opens with the first word that arrives while no frame is open. It closes after `GAP_CYCLES` consecutive cycles with no word. At the default of 32, this matches a bus gap of just over 2 µs at a 16 MHz clock.

Top module: `rt_msg_validator`

## Requirements
- R1: After reset, `status` is 0x0000, and `frame_done` and `mem_we` are low.
- R2: The frame closes on the `GAP_CYCLES`-th consecutive idle clock edge after its last word. `frame_done` is high for exactly the cycle after that edge, and `status` takes the frame's value in that same cycle. `status` then holds until the next close.
- R3: A command word carries the terminal address in bits 15:11, transmit/receive in bit 10 (1 = transmit), the subaddress in bits 9:5 and the count or mode code in bits 4:0. Address 31 is broadcast and sets status bit 3. A subaddress of 0 or 31 marks a mode command and sets status bit 4.
- R4: A parity fault sets status bit 0 when it is on any command word and bit 1 when it is on any data word. A Manchester fault sets bit 7 for a command word and bit 13 for a data word.
- R5: Status bit 5 holds the channel of the frame's first word (0 = A, 1 = B). Status bit 15 holds that word's sync type (0 = command, 1 = data).
- R6: The expected data count depends on the usable command:
  - a non-mode receive command expects its count field, where 0 means 32;
  - a transmit command expects none;
  - a receive mode command with code 17, 20 or 21 expects one;
  - any other mode command expects none.
  If the number of data words received differs from the expected count, status bit 8 is set.
- R7: A data word that arrives after 32 data words in the frame sets status bit 12. That word is not written.
- R8: A second command word counts as a terminal-to-terminal pair, and sets status bit 6, only when all of the following hold:
  - the first command was usable and was a receive command;
  - it arrives before any data word;
  - it is a transmit command.
  Every other additional command word sets status bit 11.
- R9: Status bit 9 is set when the frame has no usable command. This happens when the frame's first word is a data word, or when the first word is a command with a parity or Manchester fault.
- R10: Status bit 14 flags an illegal mode code. The legal codes are:
  - transmit with code 0–8, except broadcast code 2;
  - transmit with code 16, 18 or 19, when not broadcast;
  - receive with code 17, 20 or 21.
- R11: Status bit 10 is set when any of bits 0, 1, 7, 8, 9, 11, 12, 13 or 14 is set. Bit 2 is always 0.
- R12: The write address is base + subaddress × 32 + data word index (0 for the first data word). The base is 0 when the command names `own_addr0` or is broadcast, and 0x800 when it names `own_addr1`.
- R13: `mem_we` pulses one cycle after a data word only under all of these conditions:
  - the frame's usable first command is a non-mode receive command to either terminal or to broadcast;
  - the word has good parity and good Manchester coding;
  - the word is within the first 32 data words.
  `mem_wdata` carries that word.
- R14: Each new frame starts with a cleared working status. No bit carries over from an earlier frame, even when the new frame's first word arrives in the cycle of the previous frame's done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_valid | input | 1 | A decoded word is present this cycle |
| word_is_cmd | input | 1 | Sync type: 1 = command/status sync, 0 = data sync |
| word_data | input | 16 | Word contents |
| word_par_ok | input | 1 | Parity of the word is good |
| word_man_ok | input | 1 | Manchester coding of the word is good |
| word_chan | input | 1 | Channel of arrival: 0 = A, 1 = B |
| own_addr0 | input | 5 | Terminal address of the first terminal |
| own_addr1 | input | 5 | Terminal address of the second terminal |
| status | output | 16 | Latched status of the last closed frame |
| frame_done | output | 1 | One-cycle pulse when a frame closes |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | 12 | Buffer write address |
| mem_wdata | output | 16 | Buffer write data |

## Verification
A frame close and the opening of the next frame can fall in the same cycle. The next frame's first command word is sampled on the clock edge after the gap expires, which is exactly the cycle in which `frame_done` is high. The bench provokes this by closing a frame that carries a command-overrun error after exactly `GAP_CYCLES` idle edges, then driving a clean command word at once. It judges that `status` still shows the old frame's bits during the pulse, and that the new frame later closes with an all-zero status and a write at the second terminal's base.

// File: rtl/rtv_pkg.sv
package rtv_pkg;

    typedef struct packed {
        logic [4:0] rt;
        logic       tr;
        logic [4:0] sa;
        logic [4:0] wc;
    } cmd_t;

    localparam logic [4:0] BCAST_RT = 5'd31;

    // status bit positions
    localparam int S_CPAR  = 0;
    localparam int S_DPAR  = 1;
    localparam int S_BCAST = 3;
    localparam int S_MODE  = 4;
    localparam int S_CHAN  = 5;
    localparam int S_RTRT  = 6;
    localparam int S_CMAN  = 7;
    localparam int S_CNT   = 8;
    localparam int S_FATAL = 9;
    localparam int S_ERR   = 10;
    localparam int S_COVR  = 11;
    localparam int S_DOVR  = 12;
    localparam int S_DMAN  = 13;
    localparam int S_ILL   = 14;
    localparam int S_FIRST = 15;

    localparam logic [15:0] ERR_MASK = 16'h7B83;

    function automatic logic mode_legal(input logic [4:0] code, input logic tr,
                                        input logic bc);
        logic ok;
        ok = 1'b0;
        if (tr) begin
            if (code <= 5'd8)
                ok = !(bc && code == 5'd2);
            else if (code == 5'd16 || code == 5'd18 || code == 5'd19)
                ok = !bc;
        end else begin
            ok = (code == 5'd17 || code == 5'd20 || code == 5'd21);
        end
        return ok;
    endfunction

endpackage

// File: rtl/rtv_cmd_decode.sv
module rtv_cmd_decode
    import rtv_pkg::*;
#(
    parameter int MAX_WORDS = 32,
    localparam int CNT_W = $clog2(MAX_WORDS + 1)
) (
    input  logic [15:0]      cmd_word,
    input  logic [4:0]       own0,
    input  logic [4:0]       own1,
    output logic             tr,
    output logic [4:0]       sa,
    output logic             bcast,
    output logic             mode,
    output logic             illegal,
    output logic             stores,
    output logic             sel1,
    output logic [CNT_W-1:0] exp_cnt
);
    cmd_t c;
    logic ours;

    always_comb begin
        c       = cmd_t'(cmd_word);
        tr      = c.tr;
        sa      = c.sa;
        bcast   = (c.rt == BCAST_RT);
        mode    = (c.sa == 5'd0) || (c.sa == 5'd31);
        ours    = bcast || (c.rt == own0) || (c.rt == own1);
        sel1    = (c.rt == own1) && (c.rt != own0) && !bcast;
        stores  = ours && !c.tr && !mode;
        illegal = mode && !mode_legal(c.wc, c.tr, bcast);
        if (mode)
            exp_cnt = (!c.tr && (c.wc == 5'd17 || c.wc == 5'd20 || c.wc == 5'd21))
                      ? CNT_W'(1) : '0;
        else if (c.tr)
            exp_cnt = '0;
        else if (c.wc == 5'd0)
            exp_cnt = CNT_W'(MAX_WORDS);
        else
            exp_cnt = CNT_W'(c.wc);
    end

endmodule

// File: rtl/rtv_buf_addr.sv
module rtv_buf_addr #(
    parameter int              ADDR_W     = 12,
    parameter int              SA_W       = 5,
    parameter int              IDX_W      = 5,
    parameter logic [ADDR_W-1:0] TERM1_BASE = 12'h800
) (
    input  logic              sel1,
    input  logic [SA_W-1:0]   sa,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] slot;

    always_comb begin
        base = sel1 ? TERM1_BASE : '0;
        slot = ADDR_W'({sa, idx});
        addr = base + slot;
    end

endmodule

// File: rtl/rtv_gap_timer.sv
module rtv_gap_timer #(
    parameter int GAP_CYCLES = 32,
    localparam int GW = $clog2(GAP_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic word_seen,
    output logic expire
);
    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = active && !word_seen && (cnt_q == GW'(GAP_CYCLES - 1));
        cnt_d  = cnt_q;
        if (word_seen || !active || expire)
            cnt_d = '0;
        else
            cnt_d = cnt_q + GW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rt_msg_validator.sv
module rt_msg_validator
    import rtv_pkg::*;
#(
    parameter int              GAP_CYCLES = 32,
    parameter int              MAX_WORDS  = 32,
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] TERM1_BASE = 12'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic              word_is_cmd,
    input  logic [15:0]       word_data,
    input  logic              word_par_ok,
    input  logic              word_man_ok,
    input  logic              word_chan,
    input  logic [4:0]        own_addr0,
    input  logic [4:0]        own_addr1,
    output logic [15:0]       status,
    output logic              frame_done,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata
);
    localparam int CNT_W = $clog2(MAX_WORDS + 1);
    localparam int IDX_W = $clog2(MAX_WORDS);
    localparam int SA_W  = 5;

    typedef struct packed {
        logic              active;
        logic              cmd_ok;
        logic              first_tr;
        logic              sel1;
        logic              stores;
        logic [SA_W-1:0]   sa;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  exp_cnt;
        logic [1:0]        ncmd;
        logic [15:0]       work;
        logic [15:0]       stat;
        logic              done;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [15:0]       wdata;
    } st_t;

    st_t st_d, st_q, cur;

    logic             d_tr, d_bcast, d_mode, d_ill, d_stores, d_sel1;
    logic [4:0]       d_sa;
    logic [CNT_W-1:0] d_exp;
    logic             gap_expire;
    logic [ADDR_W-1:0] slot_addr;
    logic             word_good;
    logic [15:0]      fin;

    rtv_cmd_decode #(.MAX_WORDS(MAX_WORDS)) u_dec (
        .cmd_word (word_data),
        .own0     (own_addr0),
        .own1     (own_addr1),
        .tr       (d_tr),
        .sa       (d_sa),
        .bcast    (d_bcast),
        .mode     (d_mode),
        .illegal  (d_ill),
        .stores   (d_stores),
        .sel1     (d_sel1),
        .exp_cnt  (d_exp)
    );

    rtv_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (st_q.active),
        .word_seen (word_valid),
        .expire    (gap_expire)
    );

    // frame state as seen by an incoming word: cleared when no frame is open
    always_comb begin
        cur = st_q;
        if (!st_q.active) begin
            cur.cmd_ok   = 1'b0;
            cur.first_tr = 1'b0;
            cur.sel1     = 1'b0;
            cur.stores   = 1'b0;
            cur.sa       = '0;
            cur.cnt      = '0;
            cur.exp_cnt  = '0;
            cur.ncmd     = '0;
            cur.work     = '0;
        end
    end

    rtv_buf_addr #(
        .ADDR_W     (ADDR_W),
        .SA_W       (SA_W),
        .IDX_W      (IDX_W),
        .TERM1_BASE (TERM1_BASE)
    ) u_addr (
        .sel1 (cur.sel1),
        .sa   (cur.sa),
        .idx  (cur.cnt[IDX_W-1:0]),
        .addr (slot_addr)
    );

    always_comb begin
        word_good = word_par_ok && word_man_ok;
        fin       = st_q.work;
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.we   = 1'b0;

        if (word_valid) begin
            st_d        = cur;
            st_d.done   = 1'b0;
            st_d.we     = 1'b0;
            st_d.active = 1'b1;
            if (!st_q.active) begin
                st_d.work[S_FIRST] = !word_is_cmd;
                st_d.work[S_CHAN]  = word_chan;
            end

            if (word_is_cmd) begin
                if (!word_par_ok) st_d.work[S_CPAR] = 1'b1;
                if (!word_man_ok) st_d.work[S_CMAN] = 1'b1;
                if (!st_q.active) begin
                    if (word_good) begin
                        st_d.cmd_ok        = 1'b1;
                        st_d.first_tr      = d_tr;
                        st_d.sa            = d_sa;
                        st_d.sel1          = d_sel1;
                        st_d.stores        = d_stores;
                        st_d.exp_cnt       = d_exp;
                        st_d.work[S_BCAST] = d_bcast;
                        st_d.work[S_MODE]  = d_mode;
                        st_d.work[S_ILL]   = d_ill;
                    end
                end else if (cur.ncmd == 2'd1 && cur.cmd_ok && !cur.first_tr &&
                             cur.cnt == '0 && d_tr && !cur.work[S_RTRT]) begin
                    st_d.work[S_RTRT] = 1'b1;
                end else begin
                    st_d.work[S_COVR] = 1'b1;
                end
                if (cur.ncmd != 2'd3)
                    st_d.ncmd = cur.ncmd + 2'd1;
            end else begin
                if (!word_par_ok) st_d.work[S_DPAR] = 1'b1;
                if (!word_man_ok) st_d.work[S_DMAN] = 1'b1;
                if (cur.cnt == CNT_W'(MAX_WORDS)) begin
                    st_d.work[S_DOVR] = 1'b1;
                end else begin
                    st_d.cnt = cur.cnt + CNT_W'(1);
                    if (cur.stores && word_good) begin
                        st_d.we    = 1'b1;
                        st_d.waddr = slot_addr;
                        st_d.wdata = word_data;
                    end
                end
            end
        end else if (gap_expire) begin
            if (st_q.cmd_ok && st_q.cnt != st_q.exp_cnt)
                fin[S_CNT] = 1'b1;
            if (!st_q.cmd_ok)
                fin[S_FATAL] = 1'b1;
            fin[S_ERR]  = |(fin & ERR_MASK);
            st_d.stat   = fin;
            st_d.done   = 1'b1;
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status     = st_q.stat;
    assign frame_done = st_q.done;
    assign mem_we     = st_q.we;
    assign mem_addr   = st_q.waddr;
    assign mem_wdata  = st_q.wdata;

endmodule

// File: rtl/rtv_checker.sv
module rtv_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        word_valid,
    input logic        word_is_cmd,
    input logic        word_par_ok,
    input logic        word_man_ok,
    input logic [15:0] status,
    input logic        frame_done,
    input logic        mem_we
);
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_done_after_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !$past(word_valid));

    p_status_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable(status));

    p_write_clean_data_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(word_valid && !word_is_cmd && word_par_ok && word_man_ok));

    p_no_write_at_close_r13: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !mem_we);

endmodule

bind rt_msg_validator rtv_checker u_rtv_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_valid  (word_valid),
    .word_is_cmd (word_is_cmd),
    .word_par_ok (word_par_ok),
    .word_man_ok (word_man_ok),
    .status      (status),
    .frame_done  (frame_done),
    .mem_we      (mem_we)
);

// File: tb/rt_msg_validator_bench.sv
module rt_msg_validator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int GAP = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wv = 1'b0, wcmd = 1'b0, wpar = 1'b1, wman = 1'b1, wch = 1'b0;
    logic [15:0] wd = '0;
    logic [15:0] status;
    logic        frame_done, mem_we;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;

    int n_chk = 0, n_fail = 0, n_wr = 0;
    logic [11:0] wa [0:63];
    logic [15:0] wdat [0:63];
    bit done_flag = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rt_msg_validator #(.GAP_CYCLES(GAP)) u_rt_msg_validator (
        .clk(clk), .rst_n(rst_n), .word_valid(wv), .word_is_cmd(wcmd),
        .word_data(wd), .word_par_ok(wpar), .word_man_ok(wman), .word_chan(wch),
        .own_addr0(5'd5), .own_addr1(5'd9), .status(status),
        .frame_done(frame_done), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    always @(negedge clk) begin
        if (mem_we) begin
            if (n_wr < 64) begin
                wa[n_wr]   = mem_addr;
                wdat[n_wr] = mem_wdata;
            end
            n_wr++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic logic [15:0] cmd(input int rt, input int tr, input int sa, input int wc);
        return {rt[4:0], tr[0], sa[4:0], wc[4:0]};
    endfunction

    // drive one word at the current negedge; return at the next negedge
    task automatic put(input logic c, input logic [15:0] d, input logic pok,
                       input logic mok, input logic ch);
        wv = 1'b1; wcmd = c; wd = d; wpar = pok; wman = mok; wch = ch;
        @(negedge clk);
    endtask

    task automatic data_words(input int n, input logic ch);
        for (int i = 0; i < n; i++) put(1'b0, 16'hA000 + 16'(i), 1'b1, 1'b1, ch);
    endtask

    task automatic close_frame();
        wv = 1'b0;
        repeat (GAP + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 status", 32'(status), 32'h0);
        chk("R1 done", 32'(frame_done), 32'h0);
        chk("R1 we", 32'(mem_we), 32'h0);
    endtask

    task automatic t_basic_timing();
        n_wr = 0;
        put(1'b1, cmd(5, 0, 2, 3), 1'b1, 1'b1, 1'b1);
        data_words(3, 1'b1);
        wv = 1'b0;
        for (int k = 1; k <= GAP; k++) begin
            @(negedge clk);
            chk("R2 done timing", 32'(frame_done), (k == GAP) ? 32'h1 : 32'h0);
        end
        chk("R5 channel B status", 32'(status), 32'h0020);
        @(negedge clk);
        chk("R2 done one cycle", 32'(frame_done), 32'h0);
        chk("R13 write count", 32'(n_wr), 32'd3);
        chk("R12 addr first", 32'(wa[0]), 32'h040);
        chk("R12 addr last", 32'(wa[2]), 32'h042);
        chk("R13 write data", 32'(wdat[2]), 32'hA002);
        repeat (3) @(negedge clk);
        chk("R2 status held", 32'(status), 32'h0020);
    endtask

    task automatic t_term1_bcast();
        n_wr = 0;
        put(1'b1, cmd(9, 0, 7, 2), 1'b1, 1'b1, 1'b0);
        data_words(2, 1'b0);
        close_frame();
        chk("R12 term1 status", 32'(status), 32'h0000);
        chk("R12 term1 addr", 32'(wa[1]), 32'h8E1);
        n_wr = 0;
        put(1'b1, cmd(31, 0, 1, 1), 1'b1, 1'b1, 1'b0);
        data_words(1, 1'b0);
        close_frame();
        chk("R3 broadcast bit", 32'(status), 32'h0008);
        chk("R12 broadcast to term0", 32'(wa[0]), 32'h020);
    endtask

    task automatic t_full_and_overrun();
        n_wr = 0;
        put(1'b1, cmd(5, 0, 3, 0), 1'b1, 1'b1, 1'b0);
        data_words(32, 1'b0);
        close_frame();
        chk("R6 count 0 means 32", 32'(status), 32'h0000);
        chk("R12 last slot addr", 32'(wa[31]), 32'h07F);
        n_wr = 0;
        put(1'b1, cmd(5, 0, 3, 0), 1'b1, 1'b1, 1'b0);
        data_words(33, 1'b0);
        close_frame();
        chk("R7 data overrun", 32'(status), 32'h1400);
        chk("R7 extra not written", 32'(n_wr), 32'd32);
        put(1'b1, cmd(5, 0, 4, 5), 1'b1, 1'b1, 1'b0);
        data_words(3, 1'b0);
        close_frame();
        chk("R6 count mismatch", 32'(status), 32'h0500);
    endtask

    task automatic t_word_faults();
        n_wr = 0;
        put(1'b1, cmd(5, 0, 1, 3), 1'b1, 1'b1, 1'b0);
        put(1'b0, 16'h1111, 1'b1, 1'b1, 1'b0);
        put(1'b0, 16'h2222, 1'b0, 1'b1, 1'b0);
        put(1'b0, 16'h3333, 1'b1, 1'b0, 1'b0);
        close_frame();
        chk("R4 data parity and manchester", 32'(status), 32'h2402);
        chk("R13 bad words not written", 32'(n_wr), 32'd1);
        n_wr = 0;
        put(1'b1, cmd(5, 0, 1, 1), 1'b0, 1'b1, 1'b0);
        data_words(1, 1'b0);
        close_frame();
        chk("R4 R9 command parity", 32'(status), 32'h0601);
        chk("R13 no write without command", 32'(n_wr), 32'd0);
        put(1'b1, cmd(5, 0, 1, 1), 1'b1, 1'b0, 1'b0);
        close_frame();
        chk("R4 R9 command manchester", 32'(status), 32'h0680);
        put(1'b0, 16'h0042, 1'b1, 1'b1, 1'b0);
        close_frame();
        chk("R5 R9 data first", 32'(status), 32'h8600);
    endtask

    task automatic t_two_commands();
        n_wr = 0;
        put(1'b1, cmd(5, 0, 6, 2), 1'b1, 1'b1, 1'b0);
        put(1'b1, cmd(12, 1, 3, 2), 1'b1, 1'b1, 1'b0);
        data_words(2, 1'b0);
        close_frame();
        chk("R8 terminal pair", 32'(status), 32'h0040);
        chk("R8 pair data stored", 32'(wa[1]), 32'h0C1);
        put(1'b1, cmd(12, 1, 3, 2), 1'b1, 1'b1, 1'b0);
        put(1'b1, cmd(5, 0, 6, 2), 1'b1, 1'b1, 1'b0);
        close_frame();
        chk("R8 R11 transmit then receive", 32'(status), 32'h0C00);
    endtask

    task automatic t_modes();
        put(1'b1, cmd(5, 1, 0, 2), 1'b1, 1'b1, 1'b0);
        close_frame();
        chk("R10 legal mode", 32'(status), 32'h0010);
        put(1'b1, cmd(5, 0, 31, 3), 1'b1, 1'b1, 1'b0);
        close_frame();
        chk("R10 illegal receive mode", 32'(status), 32'h4410);
        put(1'b1, cmd(31, 1, 0, 2), 1'b1, 1'b1, 1'b0);
        close_frame();
        chk("R10 illegal broadcast mode", 32'(status), 32'h4418);
        n_wr = 0;
        put(1'b1, cmd(5, 0, 0, 17), 1'b1, 1'b1, 1'b0);
        data_words(1, 1'b0);
        close_frame();
        chk("R6 mode data word", 32'(status), 32'h0010);
        chk("R13 mode data not stored", 32'(n_wr), 32'd0);
    endtask

    task automatic t_back_to_back();
        put(1'b1, cmd(5, 0, 6, 1), 1'b1, 1'b1, 1'b0);
        data_words(1, 1'b0);
        put(1'b1, cmd(5, 0, 6, 1), 1'b1, 1'b1, 1'b0);
        wv = 1'b0;
        repeat (GAP) @(negedge clk);
        chk("R2 done at gap", 32'(frame_done), 32'h1);
        chk("R8 R11 command overrun", 32'(status), 32'h0C00);
        n_wr = 0;
        put(1'b1, cmd(9, 0, 1, 1), 1'b1, 1'b1, 1'b0);
        chk("R14 old status kept", 32'(status), 32'h0C00);
        data_words(1, 1'b0);
        close_frame();
        chk("R14 new frame clean", 32'(status), 32'h0000);
        chk("R12 term1 write", 32'(wa[0]), 32'h820);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic_timing();
        t_term1_bcast();
        t_full_and_overrun();
        t_word_faults();
        t_two_commands();
        t_modes();
        t_back_to_back();
        summary();
    end

endmodule